// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a shift register of recent branch outcomes. A lookup combines the branch PC with that history to form a table index. The counter at that index gives a taken or not-taken guess in the same cycle, with no register on the read path. When a branch resolves, its counter moves one step toward the actual outcome.

Two ways of forming the index are chosen at elaboration time. Select mode places a chosen number of low PC bits above all of the history bits. Share mode XORs the history with the same number of low PC bits, so the table has one entry per history value. A confirmed lookup shifts its own guess into the history at once. A resolved mispredict rebuilds the history from the snapshot that travelled with the branch, followed by the real outcome.

There are no named states. The only sequential parts are the counter table and the history register.

Top module: `gh_predictor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every counter holds 01 and the history is zero. A lookup then reports not taken, with a zero snapshot.
- R2: `lk_taken` is bit 1 of the counter selected by the current `lk_pc` and history. It is valid combinationally in the same cycle.
- R3: In select mode the index is `{lk_pc[SEL_PC_W-1:0], history}`, with the history in the low HIST_W bits.
- R4: In share mode the index is `lk_pc[HIST_W-1:0] XOR history`, which is HIST_W bits wide.
- R5: A resolve with `rs_taken`=1 raises the addressed counter by one, stopping at 3. A counter at 3 still predicts taken after one not-taken resolve.
- R6: A resolve with `rs_taken`=0 lowers the addressed counter by one, stopping at 0. A counter at 0 still predicts not taken after one taken resolve.
- R7: When `lk_en` is high and no mispredict repair happens, the history on the next cycle is the old history shifted left by one, with `lk_taken` in bit 0. `lk_hist` shows the history from before the shift.
- R8: When `rs_valid` and `rs_mis` are both high, the next history is `rs_snap` shifted left by one, with `rs_taken` in bit 0. This repair takes priority over a lookup in the same cycle.
- R9: With neither a confirmed lookup nor a repair, the history does not change.
- R10: A resolve updates the counter at the index formed from `rs_pc` and `rs_snap`, not from the current history. A lookup in the same cycle reads the counter value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Confirms a lookup and shifts its guess into the history |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Taken guess for `lk_pc` |
| lk_hist | output | HIST_W | History snapshot used by this lookup |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | PC of the resolving branch |
| rs_taken | input | 1 | Actual outcome: 1 is taken |
| rs_mis | input | 1 | The resolving branch was mispredicted |
| rs_snap | input | HIST_W | History snapshot carried by the resolving branch |

## Verification
A counter that ends up in the wrong state, or that is written at the wrong index, stays hidden until a later lookup reaches that entry. Then `lk_taken` flips, possibly many cycles after the faulty update. For that reason the reference table is compared on every lookup, and runs of repeated updates to one entry check both saturation limits. A history error shows up on `lk_hist` one cycle after the lookup or repair that caused it. It then corrupts the indices of every later lookup.

// File: rtl/gh_pkg.sv
package gh_pkg;

    typedef enum logic {
        IDX_SELECT = 1'b0,
        IDX_SHARE  = 1'b1
    } idx_mode_e;

    // one saturating step of a 2-bit counter toward the outcome
    function automatic logic [1:0] sat_step(input logic [1:0] ctr, input logic up);
        logic [1:0] nxt;
        if (up) nxt = (ctr == 2'b11) ? ctr : ctr + 2'b01;
        else    nxt = (ctr == 2'b00) ? ctr : ctr - 2'b01;
        return nxt;
    endfunction

endpackage

// File: rtl/gh_index.sv
module gh_index #(
    parameter gh_pkg::idx_mode_e MODE = gh_pkg::IDX_SELECT,
    parameter int PC_W     = 16,
    parameter int HIST_W   = 3,
    parameter int SEL_PC_W = 3,
    parameter int IDX_W    = SEL_PC_W + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    logic pc_unused;
    assign pc_unused = ^pc;

    generate
        if (MODE == gh_pkg::IDX_SELECT) begin : g_select
            assign idx = {pc[SEL_PC_W-1:0], hist};
        end else begin : g_share
            assign idx = pc[HIST_W-1:0] ^ hist;
        end
    endgenerate

endmodule

// File: rtl/gh_hist.sv
module gh_hist #(
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_snap,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (fix_en) begin
            hist <= HIST_W'({fix_snap, fix_bit});
        end else if (spec_en) begin
            hist <= HIST_W'({hist, spec_bit});
        end
    end

endmodule

// File: rtl/gh_pht.sv
module gh_pht #(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    logic [1:0] ctr [DEPTH];

    // read path has no register: the guess is ready in the lookup cycle
    assign rd_ctr = ctr[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr[i] <= 2'b01;
        end else if (wr_en) begin
            ctr[wr_idx] <= gh_pkg::sat_step(ctr[wr_idx], wr_up);
        end
    end

endmodule

// File: rtl/gh_predictor.sv
module gh_predictor #(
    parameter gh_pkg::idx_mode_e MODE = gh_pkg::IDX_SELECT,
    parameter int PC_W     = 16,
    parameter int HIST_W   = 3,
    parameter int SEL_PC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              rs_valid,
    input  logic [PC_W-1:0]   rs_pc,
    input  logic              rs_taken,
    input  logic              rs_mis,
    input  logic [HIST_W-1:0] rs_snap
);

    localparam int IDX_W = (MODE == gh_pkg::IDX_SELECT) ? SEL_PC_W + HIST_W : HIST_W;

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  rs_idx;
    logic [1:0]        lk_ctr;
    logic              repair;

    assign repair   = rs_valid & rs_mis;
    assign lk_taken = lk_ctr[1];
    assign lk_hist  = hist_q;

    gh_index #(.MODE(MODE), .PC_W(PC_W), .HIST_W(HIST_W), .SEL_PC_W(SEL_PC_W), .IDX_W(IDX_W))
        u_lk_idx (.pc(lk_pc), .hist(hist_q), .idx(lk_idx));

    gh_index #(.MODE(MODE), .PC_W(PC_W), .HIST_W(HIST_W), .SEL_PC_W(SEL_PC_W), .IDX_W(IDX_W))
        u_rs_idx (.pc(rs_pc), .hist(rs_snap), .idx(rs_idx));

    gh_pht #(.IDX_W(IDX_W)) u_pht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_ctr (lk_ctr),
        .wr_en  (rs_valid),
        .wr_idx (rs_idx),
        .wr_up  (rs_taken)
    );

    gh_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (lk_en),
        .spec_bit (lk_taken),
        .fix_en   (repair),
        .fix_snap (rs_snap),
        .fix_bit  (rs_taken),
        .hist     (hist_q)
    );

endmodule

// File: rtl/gh_predictor_chk.sv
module gh_predictor_chk #(
    parameter int HIST_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_en,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_hist,
    input logic              rs_valid,
    input logic              rs_taken,
    input logic              rs_mis,
    input logic [HIST_W-1:0] rs_snap
);

    // R1
    reset_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lk_hist == '0));

    // R7
    spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && !(rs_valid && rs_mis)) |=>
            (lk_hist == HIST_W'({$past(lk_hist), $past(lk_taken)})));

    // R8
    repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_mis) |=>
            (lk_hist == HIST_W'({$past(rs_snap), $past(rs_taken)})));

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_en && !(rs_valid && rs_mis)) |=> $stable(lk_hist));

    // R2
    pred_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(lk_taken));

endmodule

bind gh_predictor gh_predictor_chk #(.HIST_W(HIST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_en    (lk_en),
    .lk_taken (lk_taken),
    .lk_hist  (lk_hist),
    .rs_valid (rs_valid),
    .rs_taken (rs_taken),
    .rs_mis   (rs_mis),
    .rs_snap  (rs_snap)
);

// File: tb/sim_gh_predictor.sv
module sim_gh_predictor;

    localparam int PC_W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            lk_en;
    logic [PC_W-1:0] lk_pc;
    logic            rs_valid;
    logic [PC_W-1:0] rs_pc;
    logic            rs_taken;
    logic            rs_mis0, rs_mis1;
    logic [2:0]      rs_snap0;
    logic [5:0]      rs_snap1;
    logic            lk_taken0, lk_taken1;
    logic [2:0]      lk_hist0;
    logic [5:0]      lk_hist1;

    // select mode: 3 PC bits above 3 history bits
    gh_predictor #(.MODE(gh_pkg::IDX_SELECT), .PC_W(PC_W), .HIST_W(3), .SEL_PC_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_pc(lk_pc),
        .lk_taken(lk_taken0), .lk_hist(lk_hist0),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_mis(rs_mis0), .rs_snap(rs_snap0));

    // share mode: 6 PC bits XOR 6 history bits
    gh_predictor #(.MODE(gh_pkg::IDX_SHARE), .PC_W(PC_W), .HIST_W(6), .SEL_PC_W(3)) u1 (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_pc(lk_pc),
        .lk_taken(lk_taken1), .lk_hist(lk_hist1),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_mis(rs_mis1), .rs_snap(rs_snap1));

    int compared = 0;
    int mismatched = 0;
    int t0 [64];
    int t1 [64];
    int h0, h1;

    typedef struct { int pc; int s0; int s1; bit p0; bit p1; } br_t;
    br_t q [$];

    function automatic int ix0(int pc, int h);
        return ((pc & 7) << 3) | (h & 7);
    endfunction

    function automatic int ix1(int pc, int h);
        return (pc ^ h) & 63;
    endfunction

    function automatic int sat(int c, bit up);
        if (up) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, compare 1 ns later, advance model at posedge
    task automatic step(bit en, int pc, bit rv, int rpc, bit ract, bit m0, bit m1, int s0, int s1);
        bit p0, p1;
        lk_en = en; lk_pc = PC_W'(pc);
        rs_valid = rv; rs_pc = PC_W'(rpc); rs_taken = ract;
        rs_mis0 = m0; rs_mis1 = m1; rs_snap0 = 3'(s0); rs_snap1 = 6'(s1);
        #1;
        p0 = (t0[ix0(pc, h0)] >= 2);
        p1 = (t1[ix1(pc, h1)] >= 2);
        chk("R2 R3 R10 select prediction", int'(lk_taken0), int'(p0));
        chk("R2 R4 R10 share prediction", int'(lk_taken1), int'(p1));
        chk("R7 R8 R9 select history", int'(lk_hist0), h0);
        chk("R7 R8 R9 share history", int'(lk_hist1), h1);
        @(posedge clk);
        if (rv) begin
            t0[ix0(rpc, s0)] = sat(t0[ix0(rpc, s0)], ract);
            t1[ix1(rpc, s1)] = sat(t1[ix1(rpc, s1)], ract);
        end
        if (rv && m0)   h0 = ((s0 << 1) | int'(ract)) & 7;
        else if (en)    h0 = ((h0 << 1) | int'(p0)) & 7;
        if (rv && m1)   h1 = ((s1 << 1) | int'(ract)) & 63;
        else if (en)    h1 = ((h1 << 1) | int'(p1)) & 63;
        @(negedge clk);
    endtask

    task automatic peek(int pc);
        lk_en = 1'b0; rs_valid = 1'b0; lk_pc = PC_W'(pc);
        #1;
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int hsave;
        rst_n = 1'b0; lk_en = 1'b0; lk_pc = '0; rs_valid = 1'b0; rs_pc = '0;
        rs_taken = 1'b0; rs_mis0 = 1'b0; rs_mis1 = 1'b0; rs_snap0 = '0; rs_snap1 = '0;
        for (int i = 0; i < 64; i++) begin t0[i] = 1; t1[i] = 1; end
        h0 = 0; h1 = 0;
        repeat (2) @(negedge clk);
        lk_pc = 16'h0005; #1;
        // R1 reset state
        chk("R1 reset select prediction", int'(lk_taken0), 0);
        chk("R1 reset share prediction", int'(lk_taken1), 0);
        chk("R1 reset select history", int'(lk_hist0), 0);
        chk("R1 reset share history", int'(lk_hist1), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: drive the counter for pc 5 / history 0 to its top
        repeat (4) step(0, 0, 1, 5, 1, 0, 0, 0, 0);
        peek(5);
        chk("R5 select counter at top", int'(lk_taken0), 1);
        chk("R5 share counter at top", int'(lk_taken1), 1);
        step(0, 5, 1, 5, 0, 0, 0, 0, 0);
        peek(5);
        chk("R5 select saturated then one not-taken", int'(lk_taken0), 1);
        chk("R5 share saturated then one not-taken", int'(lk_taken1), 1);

        // R6: drive to the bottom, one taken keeps not taken
        repeat (5) step(0, 5, 1, 5, 0, 0, 0, 0, 0);
        step(0, 5, 1, 5, 1, 0, 0, 0, 0);
        peek(5);
        chk("R6 select saturated low then one taken", int'(lk_taken0), 0);
        chk("R6 share saturated low then one taken", int'(lk_taken1), 0);

        // R7: confirmed lookups shift the guess in
        step(1, 5, 0, 0, 0, 0, 0, 0, 0);
        step(1, 5, 0, 0, 0, 0, 0, 0, 0);
        // R9: idle cycles keep the history
        hsave = int'(lk_hist1);
        step(0, 7, 0, 0, 0, 0, 0, 0, 0);
        step(0, 7, 1, 3, 1, 0, 0, 1, 1);
        peek(7);
        chk("R9 share history held", int'(lk_hist1), hsave);
        // R8: repair beats a same-cycle lookup
        step(1, 5, 1, 5, 1, 1, 1, 5, 45);
        peek(5);
        chk("R8 select repaired history", int'(lk_hist0), 3);
        chk("R8 share repaired history", int'(lk_hist1), 27);

        // mixed traffic with in-flight branches (R10 via stale snapshots)
        for (int c = 0; c < 4000; c++) begin
            bit en, rv, ract, m0, m1, p0, p1;
            int pc, rpc, s0, s1;
            br_t r, nb;
            en = ($urandom % 3) != 0;
            pc = 'h100 + ($urandom % 7) * 3;
            rv = (q.size() > 0) && (($urandom % 2) == 0 || q.size() > 4);
            rpc = 0; ract = 0; m0 = 0; m1 = 0; s0 = 0; s1 = 0;
            if (rv) begin
                r = q.pop_front();
                rpc = r.pc; s0 = r.s0; s1 = r.s1;
                ract = ((r.pc % 3) == 0) ? 1'b1 : (($urandom % 4) == 0);
                m0 = (ract != r.p0); m1 = (ract != r.p1);
            end
            p0 = (t0[ix0(pc, h0)] >= 2);
            p1 = (t1[ix1(pc, h1)] >= 2);
            nb.pc = pc; nb.s0 = h0; nb.s1 = h1; nb.p0 = p0; nb.p1 = p1;
            step(en, pc, rv, rpc, ract, m0, m1, s0, s1);
            if (en) q.push_back(nb);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule